// File: doc/BRIEF.md
# Zero-Crossing Phase Sequence Counter

This block sits in each per-phase measurement slice of a polyphase meter. It measures how many voltage sample periods pass between a start event shared by all slices and the next voltage zero crossing in a chosen direction. Comparing the results of the slices then gives the phase order: the slice with the smallest count leads and the one with the largest count trails. That comparison is done outside this block.

Software arms the block with a keyed control write, which also selects the crossing direction. A falling edge on the serial receive pin then starts the count, but only if the pin stays low for a minimum time. Every slice sees that edge at the same instant, so the count is taken from the edge itself. A pulse that is too short cancels the attempt. The count advances on every sample strobe and stops at the first qualifying crossing in the programmed direction. The block then holds a saturating 7-bit result and a done flag until software arms it again.

Top module: `zxs_phase_counter`

## Requirements
- R1: After reset, `rd_data` reads 0x0000. Bit 15 is the done flag, bit 14 is the direction, bits 6:0 are the count, and all other bits read 0.
- R2: A write arms the block only when `wr_data[12:8]` equals 5'b10110 and `wr_data[15]` is 0. Such a write clears the count and the done flag and latches the direction from `wr_data[14]`, from any state. Any other write has no effect.
- R3: While armed, the block starts counting only on a falling edge of `rx_in`. The edge passes through a fixed synchroniser and no sample-dependent delay. Sample strobes that arrive before the edge are not counted.
- R4: After the edge, `rx_in` must remain low for LOW_CYCLES clock cycles (500 ns, which is 100 cycles at 200 MHz). If it returns high sooner, the block goes back to armed with a count of 0 and waits for a new edge.
- R5: From the start edge onward, each `smp_vld` strobe adds one to the count. This includes the strobes inside the low-time window.
- R6: With direction 0, counting stops at a negative-to-positive crossing. With direction 1, it stops at a positive-to-negative crossing. The strobe that carries the crossing is included in the count. A crossing in the other direction does not stop the count, and a crossing inside the low-time window does not stop it either.
- R7: A crossing is a strobed sample whose magnitude is at least `zx_level` and whose sign is opposite to that of the last sample that also reached `zx_level`. Samples smaller than `zx_level` never form a crossing.
- R8: When counting stops, the done flag (bit 15) is set and the count stays readable in bits 6:0.
- R9: The count saturates at 0x7F and does not wrap.
- R10: Once the done flag is set, edges on `rx_in` and further samples change nothing until the next keyed write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 16 | Control write data (key, done, direction) |
| rd_data | output | 16 | Control readback: done, direction, count |
| smp_vld | input | 1 | Voltage sample strobe at the output word rate |
| smp_data | input | SAMPLE_W | Signed voltage sample |
| zx_level | input | SAMPLE_W | Minimum magnitude for a crossing (unsigned) |
| rx_in | input | 1 | Serial receive pin; its qualified falling edge starts the count |

## Verification
`rx_in` passes through three register stages before its falling edge is seen, so the state change appears on `rd_data` one edge after that. The low-time qualification completes LOW_CYCLES-1 edges after the detected edge. Each strobe, and a crossing that stops the count, shows on `rd_data` at the edge that samples it. A keyed write shows at the edge that samples `wr_en`. A behavioural model in the bench takes the same three-stage input delay and updates on every rising edge. Its expected readback is compared with `rd_data` on every falling edge. Targeted checks sample several idle cycles after each stimulus, so none of them lands on a transition edge.

// File: rtl/zxs_pkg.sv
package zxs_pkg;
    localparam int RES_W = 7;
    localparam logic [4:0] ARM_KEY = 5'b10110;
    localparam int KEY_LSB  = 8;
    localparam int DONE_BIT = 15;
    localparam int DIR_BIT  = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_QUAL,
        ST_COUNT,
        ST_DONE
    } zxs_state_e;

    typedef struct packed {
        zxs_state_e       st;
        logic             done;
        logic             dir;
        logic [RES_W-1:0] cnt;
    } zxs_ctrl_t;
endpackage

// File: rtl/zxs_rx_qual.sv
module zxs_rx_qual #(
    parameter int LOW_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic fall_o,
    output logic rise_o,
    output logic low_o,
    output logic qual_o
);
    localparam int LCW = $clog2(LOW_CYCLES + 1);

    typedef struct packed {
        logic           s1;
        logic           s2;
        logic           prev;
        logic [LCW-1:0] low_cnt;
    } rxq_t;

    rxq_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.s1   = rx_i;
        r_d.s2   = r_q.s1;
        r_d.prev = r_q.s2;
        if (r_q.s2) begin
            r_d.low_cnt = '0;
        end else if (r_q.low_cnt != LCW'(LOW_CYCLES)) begin
            r_d.low_cnt = r_q.low_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1, low_cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign low_o  = ~r_q.s2;
    assign fall_o = r_q.prev & ~r_q.s2;
    assign rise_o = ~r_q.prev & r_q.s2;
    assign qual_o = ~r_q.s2 && (r_q.low_cnt == LCW'(LOW_CYCLES - 1));

    // R4
    qual_needs_low_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |-> (low_o && $past(low_o)));

    // R3
    fall_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> (!rise_o));
endmodule

// File: rtl/zxs_zero_cross.sv
module zxs_zero_cross #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic [SAMPLE_W-1:0] level_i,
    output logic                up_o,
    output logic                down_o
);
    typedef struct packed {
        logic valid;
        logic neg;
    } zc_t;

    zc_t r_d, r_q;

    logic                neg;
    logic [SAMPLE_W-1:0] mag;
    logic                big;

    always_comb begin
        neg    = smp_i[SAMPLE_W-1];
        mag    = neg ? (~smp_i + 1'b1) : smp_i;
        big    = vld_i && (mag >= level_i);
        up_o   = big && r_q.valid && r_q.neg && !neg;
        down_o = big && r_q.valid && !r_q.neg && neg;
        r_d    = r_q;
        if (big) begin
            r_d.valid = 1'b1;
            r_d.neg   = neg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R7
    up_sets_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_o |=> (r_q.valid && !r_q.neg));

    // R7
    down_sets_negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
        down_o |=> (r_q.valid && r_q.neg));

    // R7
    single_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_o && down_o));
endmodule

// File: rtl/zxs_phase_counter.sv
module zxs_phase_counter
    import zxs_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int CLK_FREQ_HZ = 200_000_000,
    parameter int MIN_LOW_NS  = 500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [15:0]         wr_data,
    output logic [15:0]         rd_data,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-1:0] zx_level,
    input  logic                rx_in
);
    localparam int CLK_MHZ    = CLK_FREQ_HZ / 1_000_000;
    localparam int LOW_RAW    = (CLK_MHZ * MIN_LOW_NS + 999) / 1000;
    localparam int LOW_CYCLES = (LOW_RAW < 2) ? 2 : LOW_RAW;
    localparam logic [RES_W-1:0] CNT_MAX = '1;

    logic rx_fall, rx_rise, rx_low, rx_qual;
    logic zc_up, zc_down;

    zxs_rx_qual #(.LOW_CYCLES(LOW_CYCLES)) u_rx_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_in),
        .fall_o (rx_fall),
        .rise_o (rx_rise),
        .low_o  (rx_low),
        .qual_o (rx_qual)
    );

    zxs_zero_cross #(.SAMPLE_W(SAMPLE_W)) u_zero_cross (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (smp_vld),
        .smp_i   (smp_data),
        .level_i (zx_level),
        .up_o    (zc_up),
        .down_o  (zc_down)
    );

    zxs_ctrl_t r_d, r_q;
    logic             key_wr;
    logic             stop_hit;
    logic [RES_W-1:0] cnt_inc;
    logic             wr_unused;

    assign wr_unused = ^{wr_data[13], wr_data[7:0], rx_low};

    always_comb begin
        key_wr   = wr_en && (wr_data[KEY_LSB +: 5] == ARM_KEY) && !wr_data[DONE_BIT];
        stop_hit = r_q.dir ? zc_down : zc_up;
        cnt_inc  = (r_q.cnt == CNT_MAX) ? r_q.cnt : r_q.cnt + 1'b1;
        r_d      = r_q;
        if (key_wr) begin
            r_d.st   = ST_ARMED;
            r_d.cnt  = '0;
            r_d.done = 1'b0;
            r_d.dir  = wr_data[DIR_BIT];
        end else begin
            unique case (r_q.st)
                ST_ARMED: begin
                    if (rx_fall) r_d.st = ST_QUAL;
                end
                ST_QUAL: begin
                    if (rx_rise) begin
                        r_d.st  = ST_ARMED;
                        r_d.cnt = '0;
                    end else begin
                        if (smp_vld) r_d.cnt = cnt_inc;
                        if (rx_qual) r_d.st  = ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    if (smp_vld) r_d.cnt = cnt_inc;
                    if (stop_hit) begin
                        r_d.st   = ST_DONE;
                        r_d.done = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, done: 1'b0, dir: 1'b0, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data = {r_q.done, r_q.dir, 7'b0, r_q.cnt};

    // R2
    arm_on_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> (r_q.st == ST_ARMED && !r_q.done && r_q.cnt == '0));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DONE && !key_wr) |=> (r_q.st == ST_DONE && r_q.done && $stable(r_q.cnt)));

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cnt == CNT_MAX && r_q.st != ST_QUAL && !key_wr) |=> (r_q.cnt == CNT_MAX));

    // R8
    done_from_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.done) |-> ($past(r_q.st) == ST_COUNT && $past(smp_vld)));

    // R4
    short_pulse_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_QUAL && rx_rise && !key_wr) |=> (r_q.st == ST_ARMED && r_q.cnt == '0));

    // R3
    armed_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ARMED && !key_wr) |=> (r_q.cnt == '0));
endmodule

// File: tb/zxs_phase_counter_bench.sv
`timescale 1ns/1ps
module zxs_phase_counter_bench;
    localparam int SW  = 24;
    localparam int LOW = 100;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0;
    logic [15:0]          wr_data = '0;
    logic [15:0]          rd_data;
    logic                 smp_vld = 1'b0;
    logic signed [SW-1:0] smp_data = '0;
    logic [SW-1:0]        zx_level = SW'(100);
    logic                 rx_in = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit run = 1'b0;

    always #2.5 clk = ~clk;

    zxs_phase_counter #(.SAMPLE_W(SW), .CLK_FREQ_HZ(200_000_000), .MIN_LOW_NS(500)) u_zxs_phase_counter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .smp_vld(smp_vld), .smp_data(smp_data), .zx_level(zx_level), .rx_in(rx_in)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 armed, 2 low-time window, 3 counting, 4 done
    int m_mode, m_cnt, m_low, m_sv, m_mag;
    bit m_done, m_dir, m_refv, m_refneg;
    bit m_a, m_b, m_c;
    bit m_big, m_up, m_dn, m_key, m_stop, m_s, m_p;
    logic [15:0] m_exp;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_low = 0; m_done = 0; m_dir = 0;
            m_refv = 0; m_refneg = 0; m_a = 1; m_b = 1; m_c = 1; m_exp = '0;
        end else begin
            m_s   = m_b;
            m_p   = m_c;
            m_sv  = int'(smp_data);
            m_mag = (m_sv < 0) ? -m_sv : m_sv;
            m_big = smp_vld && (m_mag >= int'(zx_level));
            m_up  = m_big && m_refv && m_refneg && (m_sv >= 0);
            m_dn  = m_big && m_refv && !m_refneg && (m_sv < 0);
            m_key = wr_en && (wr_data[12:8] == 5'h16) && !wr_data[15];
            m_stop = m_dir ? m_dn : m_up;
            if (m_key) begin
                m_mode = 1; m_cnt = 0; m_done = 0; m_dir = wr_data[14];
            end else if (m_mode == 1) begin
                if (m_p && !m_s) m_mode = 2;
            end else if (m_mode == 2) begin
                if (!m_p && m_s) begin
                    m_mode = 1; m_cnt = 0;
                end else begin
                    if (smp_vld && m_cnt < 127) m_cnt++;
                    if (!m_s && m_low == LOW - 1) m_mode = 3;
                end
            end else if (m_mode == 3) begin
                if (smp_vld && m_cnt < 127) m_cnt++;
                if (m_stop) begin
                    m_mode = 4; m_done = 1;
                end
            end
            if (m_big) begin
                m_refv = 1; m_refneg = (m_sv < 0);
            end
            m_low = m_s ? 0 : ((m_low < LOW) ? m_low + 1 : LOW);
            m_c = m_b; m_b = m_a; m_a = rx_in;
            m_exp = {m_done, m_dir, 7'b0, 7'(m_cnt)};
        end
    end

    always @(negedge clk) begin
        if (rst_n && run) check("R3/R5/R6 per-cycle model", rd_data, m_exp);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic send(input int v);
        @(negedge clk);
        smp_vld = 1'b1; smp_data = SW'(v);
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        run = 1'b1;
        idle(2);
        check("R1 reset readback", rd_data, 16'h0000);

        // ignored write with a wrong key
        reg_write(16'h1500);
        rx_in = 1'b0; idle(10); send(-500); idle(5);
        check("R2 wrong key ignored", rd_data, 16'h0000);

        // scenario A: direction 0
        rx_in = 1'b1; idle(10);
        reg_write(16'h1600); idle(3);
        rx_in = 1'b0; idle(20);
        send(-400); idle(120);
        send(-50); send(50); idle(3);
        check("R7 small swing ignored, R5 count", rd_data, 16'h0003);
        send(300); idle(3);
        check("R6 rising stop, R8 done", rd_data, 16'h8004);
        rx_in = 1'b1; idle(5); rx_in = 1'b0; idle(120);
        send(-300); send(300); idle(3);
        check("R10 ignored after done", rd_data, 16'h8004);

        // scenario B: direction 1, with a short pulse first
        rx_in = 1'b1; idle(10);
        reg_write(16'h5600); idle(3);
        check("R2 keyed write latches dir", rd_data, 16'h4000);
        rx_in = 1'b0; idle(10); send(200); idle(10);
        rx_in = 1'b1; idle(10);
        check("R4 short pulse aborts", rd_data, 16'h4000);
        rx_in = 1'b0; idle(20); send(250); idle(110);
        send(150); send(-80); send(-200); idle(3);
        check("R6 falling stop dir1", rd_data, 16'hC004);

        // scenario C: saturation
        rx_in = 1'b1; idle(10);
        reg_write(16'h1600); idle(3);
        rx_in = 1'b0; idle(5);
        for (int i = 0; i < 130; i++) begin
            send(-300); idle(1);
        end
        check("R9 saturate at 7F", rd_data, 16'h007F);
        send(300); idle(3);
        check("R9 R8 saturated done", rd_data, 16'h807F);

        // scenario D: wrong-direction crossing
        rx_in = 1'b1; idle(10);
        reg_write(16'h1600); idle(3);
        rx_in = 1'b0; idle(110);
        send(-300); idle(3);
        check("R6 opposite crossing ignored", rd_data, 16'h0001);
        send(300); idle(3);
        check("R6 stop after opposite", rd_data, 16'h8002);

        // scenario E: writes that must not arm
        reg_write(16'h9600); idle(3);
        check("R2 done bit set ignored", rd_data, 16'h8002);
        reg_write(16'h1500); idle(3);
        check("R2 wrong key after done", rd_data, 16'h8002);

        // scenario F: re-arm mid-count, no edge afterwards
        rx_in = 1'b1; idle(10);
        reg_write(16'h1600); idle(3);
        rx_in = 1'b0; idle(110);
        send(-300); idle(3);
        check("R5 counting before rearm", rd_data, 16'h0001);
        reg_write(16'h1600); idle(3);
        check("R2 rearm mid-count clears", rd_data, 16'h0000);
        send(300); send(-300); idle(3);
        check("R3 no start without edge", rd_data, 16'h0000);

        idle(5);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule